// File: doc/BRIEF.md
# Event Prescaler with Snapshot Counter

This block takes a bus of 32 event lines and picks one with a source field. Each rising edge of the chosen line advances a divider and a 16-bit edge counter. The divider drives a square-wave event output that changes level every half-ratio edges, so a downstream measurement controller can use it as a start or stop source. The output toggles after every 8 edges for a divide-by-16 ratio, or after every 32 edges for a divide-by-64 ratio. The edge counter wraps freely. Software cannot read the live count. A write to the counter address copies the live count into a snapshot register, and reads at that address return the snapshot.

A run bit in the control register acts as an active-low hold for the prescaler. While it is 0, the divider phase, the output and the edge counter are all held at zero. The source and ratio fields must be changed only while the block is in hold. The register port is a plain single-cycle write strobe with a combinational read mux. There is no data stream, so no valid/ready handshake and no back-pressure exist.

Top module: `evt_prescaler`

## Requirements
- R1: After rst_n is released, the control register reads 0x7C: run = 0, ratio = 0, source = 31. The snapshot reads 0 and ev_out is 0.
- R2: While run = 0, ev_out stays 0 and edges on the selected input are not counted, so a capture taken in hold reads 0.
- R3: With ratio = 0, ev_out toggles on every 8th counted rising edge, starting from 0 when the block leaves hold.
- R4: With ratio = 1, ev_out toggles on every 32nd counted rising edge.
- R5: Only ev_in[source] is counted. Edges on other lines have no effect on ev_out or the count.
- R6: An edge is counted when the selected input is 1 in a clock cycle and was 0 in the previous cycle. At most one edge is counted per clock, and a level held high counts once. An input that is already high when the block leaves hold is not counted.
- R7: A write with reg_addr = 1 copies the live count, as it stands before that cycle's edge, into the snapshot. The written data is ignored. Reads with reg_addr = 1 return the snapshot.
- R8: The edge count wraps modulo 65536.
- R9: The snapshot keeps its value through hold and is cleared only by rst_n.
- R10: The control register maps run to bit 0, ratio to bit 1 and source to bits 6:2. It reads back through reg_rdata with bits 15:7 zero when reg_addr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 32 | Event lines, already synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = counter snapshot |
| reg_wdata | input | 7 | Write data (control fields; ignored for the counter address) |
| reg_rdata | output | 16 | Read data for reg_addr |
| ev_out | output | 1 | Divided event output |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- ev_out clears while in hold.
- ev_out changes only after a detected edge.
- Edges never occur on two consecutive cycles.
- The counter steps by exactly one per edge and is otherwise stable.
- The snapshot moves only on a capture.

Only the bench scenarios can show the following:
- The exact toggle spacing for each ratio.
- That no edge is counted on leaving hold with the input high.
- Source isolation.
- Wrap at 65536.
- That the snapshot survives hold.

// File: rtl/evt_prescaler_pkg.sv
package evt_prescaler_pkg;
  localparam int EVT_N  = 32;
  localparam int SEL_W  = $clog2(EVT_N);
  localparam int CNT_W  = 16;
  localparam int DIV_LO = 16;
  localparam int DIV_HI = 64;

  typedef struct packed {
    logic [SEL_W-1:0] src;
    logic             ratio;
    logic             run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{src: SEL_W'(EVT_N - 1), ratio: 1'b0, run: 1'b0};
endpackage

// File: rtl/evt_edge_sel.sv
module evt_edge_sel
  import evt_prescaler_pkg::*;
#(
  parameter int N = EVT_N,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ev_i,
  input  logic [SW-1:0] src_i,
  input  logic          run_i,
  output logic          edge_o
);
  logic sel;
  logic prev_q;

  assign sel = ev_i[src_i];

  // previous level tracks even in hold so leaving hold never makes a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel;
  end

  assign edge_o = run_i & sel & ~prev_q;

  p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o ##1 $stable(src_i) |-> !edge_o);
endmodule

// File: rtl/evt_divider.sv
module evt_divider
  import evt_prescaler_pkg::*;
#(
  parameter int LO = DIV_LO,
  parameter int HI = DIV_HI,
  localparam int HALF_LO = LO / 2,
  localparam int HALF_HI = HI / 2,
  localparam int PH_W = $clog2(HALF_HI)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ratio_i,
  input  logic edge_i,
  output logic out_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] lim;
  logic            out_q;

  assign lim = ratio_i ? PH_W'(HALF_HI - 1) : PH_W'(HALF_LO - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      out_q   <= 1'b0;
    end else if (!run_i) begin
      phase_q <= '0;
      out_q   <= 1'b0;
    end else if (edge_i) begin
      if (phase_q >= lim) begin
        phase_q <= '0;
        out_q   <= ~out_q;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign out_o = out_q;

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !out_o);
  p_toggle_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !edge_i |=> $stable(out_o));
endmodule

// File: rtl/evt_snap_cnt.sv
module evt_snap_cnt
  import evt_prescaler_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         edge_i,
  input  logic         cap_i,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (edge_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (cap_i) snap_q <= cnt_q;
  end

  assign snap_o = snap_q;

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && edge_i |=> cnt_q == W'($past(cnt_q) + 1'b1));
  p_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !edge_i |=> $stable(cnt_q));
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(snap_q));
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler
  import evt_prescaler_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  ev_in,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              ev_out
);
  localparam int PAD_W = CNT_W - CTRL_W;

  ctrl_t            ctrl_q;
  logic             edge_w;
  logic             cap_w;
  logic [CNT_W-1:0] snap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctrl_q <= CTRL_RST;
    else if (reg_wr && !reg_addr) ctrl_q <= ctrl_t'(reg_wdata);
  end

  assign cap_w = reg_wr & reg_addr;

  evt_edge_sel #(.N(EVT_N)) u_sel (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_in), .src_i(ctrl_q.src),
    .run_i(ctrl_q.run), .edge_o(edge_w)
  );

  evt_divider #(.LO(DIV_LO), .HI(DIV_HI)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.run), .ratio_i(ctrl_q.ratio),
    .edge_i(edge_w), .out_o(ev_out)
  );

  evt_snap_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.run), .edge_i(edge_w),
    .cap_i(cap_w), .snap_o(snap_w)
  );

  assign reg_rdata = reg_addr ? snap_w : {{PAD_W{1'b0}}, ctrl_q};

  p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_addr |=> ctrl_q == $past(reg_wdata));
endmodule

// File: tb/test_evt_prescaler.sv
`timescale 1ns/1ps
module test_evt_prescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ev_in = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [6:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ev_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_prescaler i_evt_prescaler (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_out(ev_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: counts edges since leaving hold as a plain integer
  bit m_run, m_ratio, m_prev, m_out;
  int m_src, m_edges, m_snap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_ratio = 0; m_src = 31; m_prev = 0;
      m_edges = 0; m_snap = 0; m_out = 0;
    end else begin
      bit s, e;
      s = ev_in[m_src];
      e = m_run && s && !m_prev;
      if (reg_wr && reg_addr) m_snap = m_edges % 65536;
      if (!m_run) m_edges = 0;
      else if (e) m_edges++;
      m_out = m_run ? ((m_edges / (m_ratio ? 32 : 8)) % 2 == 1) : 0;
      m_prev = s;
      if (reg_wr && !reg_addr) begin
        m_run = reg_wdata[0]; m_ratio = reg_wdata[1]; m_src = int'(reg_wdata[6:2]);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R3 R4 ev_out vs model", int'(ev_out), int'(m_out));
      check("R7 R10 rdata vs model", int'(reg_rdata),
            reg_addr ? m_snap : ((m_src << 2) | (int'(m_ratio) << 1) | int'(m_run)));
    end
  end

  task automatic wr(input bit a, input logic [6:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input bit a, input string req, input int exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, int'(reg_rdata), exp);
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ev_in[idx] = 1'b1;
      @(negedge clk); ev_in[idx] = 1'b0;
    end
  endtask

  task automatic outchk(input string req, input bit exp);
    @(negedge clk); check(req, int'(ev_out), int'(exp));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    outchk("R1 ev_out after reset", 0);
    rd(0, "R1 control reset value", 'h7C);
    rd(1, "R1 snapshot reset value", 0);
    // R2 hold ignores edges
    wr(0, 7'h0C);
    pulse(3, 10);
    outchk("R2 ev_out in hold", 0);
    wr(1, 7'h7F);
    rd(1, "R2 capture in hold", 0);
    // R3 divide by 16
    wr(0, 7'h0D);
    rd(0, "R10 control readback", 'h0D);
    pulse(3, 7);
    outchk("R3 no toggle after 7 edges", 0);
    pulse(3, 1);
    outchk("R3 toggle after 8 edges", 1);
    pulse(3, 8);
    outchk("R3 toggle back after 16 edges", 0);
    // R5 other line ignored
    pulse(5, 20);
    outchk("R5 unselected line", 0);
    wr(1, 7'h34);
    rd(1, "R5 R7 capture count 16", 16);
    // R6 long high level counts once
    @(negedge clk); ev_in[3] = 1'b1;
    repeat (10) @(negedge clk);
    ev_in[3] = 1'b0;
    wr(1, 7'h00);
    rd(1, "R6 held level counts once", 17);
    // R9 snapshot survives hold; R6 no edge on leaving hold with input high
    wr(0, 7'h0C);
    rd(1, "R9 snapshot in hold", 17);
    @(negedge clk); ev_in[3] = 1'b1;
    wr(0, 7'h0D);
    repeat (3) @(negedge clk);
    ev_in[3] = 1'b0;
    wr(1, 7'h55);
    rd(1, "R6 no edge on leaving hold", 0);
    // R4 divide by 64
    wr(0, 7'h0E);
    rd(0, "R10 ratio readback", 'h0E);
    wr(0, 7'h0F);
    pulse(3, 31);
    outchk("R4 no toggle after 31 edges", 0);
    pulse(3, 1);
    outchk("R4 toggle after 32 edges", 1);
    // R8 wrap: 32 + 65510 = 65542 -> 6
    pulse(3, 65510);
    outchk("R8 output after many edges", 0);
    wr(1, 7'h00);
    rd(1, "R8 count wraps", 6);
    // R9 reset clears snapshot
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(1, "R9 snapshot cleared by reset", 0);
    rd(0, "R1 control after second reset", 'h7C);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule